// File: doc/BRIEF.md
# Register redirection table

This block is a small associative table consulted while an instruction's register operands are decoded. Each of its sixteen entries is a configuration word. The word names an architectural register number and an integer or floating-point type. It also gives the physical register that number should really use, and it re-types that register. The new type says whether the register is a vector or a scalar, which element width it carries and whether it holds packed SIMD elements.

Software fills entries through a one-word write port, addressed by entry index. Decode presents a 5-bit register number and a type select. In the same cycle the block returns a hit flag and the redirected 6-bit index with its three type fields. When nothing matches, the register number passes through unchanged as a scalar of default width. Integer and floating-point lookups are separate namespaces, so the table acts as two independent 32-register views.

The block has no sequencing of its own, so there are no states or transitions. Only the entry storage holds state: each entry has one valid flag and one stored word. Reset clears every valid flag, and a write sets the flag of the entry it addresses.

Top module: `regmap_cam`

## Requirements
- R1: After reset every entry is invalid, so every lookup of either type misses.
- R2: A write on `cfg_we` stores `cfg_word` into entry `cfg_idx` and marks the entry valid. Lookups see the new contents from the next rising clock edge and not in the cycle of the write.
- R3: A hit returns fields taken from the winning entry's word. Bit 15 gives `dec_simd`, bit 13 gives `dec_vec`, bits 12..11 give `dec_ew` and bits 9..5 give `dec_phys[4:0]`. The `dec_ew` codes are 00 default width, 01 half width, 10 double width and 11 fixed 8 bits.
- R4: An entry matches only when its bits 4..0 equal `dec_reg` and its bit 10 equals `dec_fp`, where 0 means integer and 1 means floating point. A key written for one type never hits a lookup of the other type.
- R5: On a miss, `dec_hit` is 0, `dec_phys` is `{1'b0, dec_reg}`, `dec_vec` is 0, `dec_ew` is 00 and `dec_simd` is 0.
- R6: When several valid entries match the same key and type, the entry with the highest index supplies the result.
- R7: The bank bit (bit 14 of the word) is reserved. It is stored as 0 whatever is written, so `dec_phys[5]` is always 0.
- R8: The lookup is combinational. Outputs follow `dec_reg` and `dec_fp` in the same cycle, with no clock edge in between.
- R9: Rewriting an entry replaces all of its previous contents. A key it held before no longer hits through that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| cfg_we | input | 1 | Write strobe for one entry |
| cfg_idx | input | 4 | Index of the entry being written |
| cfg_word | input | 16 | Configuration word to store |
| dec_reg | input | 5 | Architectural register number being decoded |
| dec_fp | input | 1 | Lookup type: 0 integer, 1 floating point |
| dec_hit | output | 1 | A valid entry matched |
| dec_phys | output | 6 | Redirected register index, bank in bit 5 |
| dec_vec | output | 1 | Register is treated as a vector |
| dec_ew | output | 2 | Element-width code |
| dec_simd | output | 1 | Register holds packed SIMD elements |

## Verification
The hardest case to reach from the ports is a priority conflict: two or more valid entries with the same key and type but different redirect targets. In that case the highest index must win, and a lower-index rewrite must leave the result unchanged. Random writes draw keys from only eight register numbers and pick the type at random, so duplicate keys appear often and entries are overwritten many times. Directed cases add a conflict between entries 2 and 9, lookups issued in the same cycle as a write, a reserved bank bit written as 1, and integer and floating-point entries that share one key.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    localparam int unsigned KEY_W  = 5;
    localparam int unsigned EW_W   = 2;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned PHYS_W = KEY_W + 1;

    typedef enum logic [EW_W-1:0] {
        EW_NATIVE = 2'b00,
        EW_HALF   = 2'b01,
        EW_DOUBLE = 2'b10,
        EW_BYTE   = 2'b11
    } ew_e;

    // field order matters: a decoder reads these bit positions
    typedef struct packed {
        logic             simd;
        logic             bank;
        logic             vec;
        ew_e              ew;
        logic             fp;
        logic [KEY_W-1:0] tgt;
        logic [KEY_W-1:0] key;
    } cfg_t;

    // reserved bank bit is always stored as zero
    function automatic cfg_t scrub_word(input logic [WORD_W-1:0] w);
        cfg_t c;
        c      = cfg_t'(w);
        c.bank = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/regmap_store.sv
module regmap_store
    import regmap_pkg::*;
#(
    parameter int unsigned N_ENT = 16,
    localparam int unsigned IW   = $clog2(N_ENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  logic [WORD_W-1:0]       wr_word,
    output cfg_t [N_ENT-1:0]        ent_q,
    output logic [N_ENT-1:0]        vld_q
);

    cfg_t clean;
    assign clean = scrub_word(wr_word);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                ent_q[i] <= '0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                vld_q[i] <= 1'b1;
                ent_q[i] <= clean;
            end
        end
    end

    // R1: nothing valid in the first cycle out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld_q == '0));

    // R2 / R9: a write lands in the addressed entry by the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < int'(N_ENT))) |=>
            (vld_q[$past(wr_idx)] && (ent_q[$past(wr_idx)] == scrub_word($past(wr_word)))));

    // R2: without a write the valid flags do not move
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld_q));

endmodule

// File: rtl/regmap_match.sv
module regmap_match
    import regmap_pkg::*;
#(
    parameter int unsigned N_ENT = 16
) (
    input  cfg_t [N_ENT-1:0]   ent_q,
    input  logic [N_ENT-1:0]   vld_q,
    input  logic [KEY_W-1:0]   key,
    input  logic               fp,
    output logic [N_ENT-1:0]   hit_vec
);

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit_vec[i] = vld_q[i] && (ent_q[i].key == key) && (ent_q[i].fp == fp);
    end

endmodule

// File: rtl/regmap_pick.sv
module regmap_pick #(
    parameter int unsigned N_ENT = 16,
    localparam int unsigned IW   = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ENT-1:0]  hit_vec,
    output logic              any,
    output logic [IW-1:0]     sel
);

    // later index overrides earlier: highest matching entry wins
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = 0; i < int'(N_ENT); i++) begin
            if (hit_vec[i]) begin
                any = 1'b1;
                sel = IW'(i);
            end
        end
    end

    // R6: chosen entry matches and no higher entry matches
    a_r6_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (hit_vec[sel] && ((hit_vec >> sel) == N_ENT'(1))));

endmodule

// File: rtl/regmap_cam.sv
module regmap_cam
    import regmap_pkg::*;
#(
    parameter int unsigned N_ENT = 16,
    localparam int unsigned IW   = $clog2(N_ENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IW-1:0]       cfg_idx,
    input  logic [WORD_W-1:0]   cfg_word,
    input  logic [KEY_W-1:0]    dec_reg,
    input  logic                dec_fp,
    output logic                dec_hit,
    output logic [PHYS_W-1:0]   dec_phys,
    output logic                dec_vec,
    output logic [EW_W-1:0]     dec_ew,
    output logic                dec_simd
);

    cfg_t [N_ENT-1:0]  ent_q;
    logic [N_ENT-1:0]  vld_q;
    logic [N_ENT-1:0]  hit_vec;
    logic              any;
    logic [IW-1:0]     sel;

    regmap_store #(.N_ENT(N_ENT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_word (cfg_word),
        .ent_q   (ent_q),
        .vld_q   (vld_q)
    );

    regmap_match #(.N_ENT(N_ENT)) u_match (
        .ent_q   (ent_q),
        .vld_q   (vld_q),
        .key     (dec_reg),
        .fp      (dec_fp),
        .hit_vec (hit_vec)
    );

    regmap_pick #(.N_ENT(N_ENT)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_vec (hit_vec),
        .any     (any),
        .sel     (sel)
    );

    always_comb begin
        if (any) begin
            dec_hit  = 1'b1;
            dec_phys = {ent_q[sel].bank, ent_q[sel].tgt};
            dec_vec  = ent_q[sel].vec;
            dec_ew   = ent_q[sel].ew;
            dec_simd = ent_q[sel].simd;
        end else begin
            dec_hit  = 1'b0;
            dec_phys = {1'b0, dec_reg};
            dec_vec  = 1'b0;
            dec_ew   = EW_NATIVE;
            dec_simd = 1'b0;
        end
    end

    // R5: a miss leaves the register untouched and scalar
    a_r5_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_hit |-> ((dec_phys == {1'b0, dec_reg}) && !dec_vec && (dec_ew == 2'b00) && !dec_simd));

    // R7: reserved bank never reaches the redirected index
    a_r7_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dec_phys[PHYS_W-1] == 1'b0);

    // R1: first cycle out of reset, every lookup misses
    a_r1_first_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dec_hit);

endmodule

// File: tb/sim_regmap_cam.sv
module sim_regmap_cam;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_word = '0;
    logic [4:0]  dec_reg = '0;
    logic        dec_fp = 1'b0;
    logic        dec_hit;
    logic [5:0]  dec_phys;
    logic        dec_vec;
    logic [1:0]  dec_ew;
    logic        dec_simd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] m_word [16];
    bit          m_vld  [16];

    always #5 clk = ~clk;

    regmap_cam u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
        .dec_reg(dec_reg), .dec_fp(dec_fp), .dec_hit(dec_hit), .dec_phys(dec_phys),
        .dec_vec(dec_vec), .dec_ew(dec_ew), .dec_simd(dec_simd)
    );

    function automatic logic [15:0] mk(input bit simd, input bit bank, input bit vec,
                                       input logic [1:0] ew, input bit fp,
                                       input logic [4:0] tgt, input logic [4:0] key);
        return {simd, bank, vec, ew, fp, tgt, key};
    endfunction

    // expected {hit, phys[5:0], vec, ew[1:0], simd}
    function automatic logic [10:0] expect_of(input logic [4:0] r, input bit fp);
        logic [10:0] e;
        e = {1'b0, 1'b0, r, 1'b0, 2'b00, 1'b0};
        for (int i = 0; i < 16; i++) begin
            if (m_vld[i] && m_word[i][4:0] == r && m_word[i][10] == fp)
                e = {1'b1, 1'b0, m_word[i][9:5], m_word[i][13], m_word[i][12:11], m_word[i][15]};
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [4:0] r, input bit fp);
        logic [10:0] got, exp;
        dec_reg = r;
        dec_fp  = fp;
        #1;
        got = {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd};
        exp = expect_of(r, fp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s reg=%0d fp=%0d actual=%h expected=%h", req, r, fp, got, exp);
        end
    endtask

    task automatic check_val(input string req, input logic [10:0] got, input logic [10:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_word = w;
        @(posedge clk);
        m_vld[idx]  = 1'b1;
        m_word[idx] = w & 16'hbfff;
        #1 cfg_we = 1'b0;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_word[i] = '0; end
        repeat (3) @(posedge clk);
        #2 check("R1 during reset", 5'd3, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: all registers miss after reset, both types
        for (int r = 0; r < 32; r += 7) begin
            check("R1", 5'(r), 1'b0);
            check("R1", 5'(r), 1'b1);
        end

        // R3: field positions, simd=1 vec=1 ew=10 tgt=17 key=3 int
        wr(4'd0, mk(1, 0, 1, 2'b10, 0, 5'd17, 5'd3));
        dec_reg = 5'd3; dec_fp = 1'b0; #1;
        check_val("R3 fields", {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd},
                  {1'b1, 6'd17, 1'b1, 2'b10, 1'b1});
        // R4: same key, fp lookup misses
        check("R4 type split", 5'd3, 1'b1);
        // R5: different register misses
        dec_reg = 5'd4; dec_fp = 1'b0; #1;
        check_val("R5 passthru", {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd},
                  {1'b0, 6'd4, 1'b0, 2'b00, 1'b0});
        // R4: fp entry on same key with other target
        wr(4'd1, mk(0, 0, 0, 2'b11, 1, 5'd29, 5'd3));
        check("R4 fp view", 5'd3, 1'b1);
        check("R4 int view", 5'd3, 1'b0);

        // R7: bank bit written as 1 is dropped
        wr(4'd5, mk(0, 1, 1, 2'b01, 0, 5'd31, 5'd10));
        dec_reg = 5'd10; dec_fp = 1'b0; #1;
        check_val("R7 bank", {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd},
                  {1'b1, 6'd31, 1'b1, 2'b01, 1'b0});

        // R6: entries 2 and 9 share key 12, higher wins
        wr(4'd9, mk(0, 0, 1, 2'b00, 0, 5'd20, 5'd12));
        wr(4'd2, mk(1, 0, 0, 2'b11, 0, 5'd8,  5'd12));
        dec_reg = 5'd12; dec_fp = 1'b0; #1;
        check_val("R6 priority", {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd},
                  {1'b1, 6'd20, 1'b1, 2'b00, 1'b0});

        // R2: write not visible in its own cycle, visible after edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'd7; cfg_word = mk(0, 0, 1, 2'b01, 1, 5'd2, 5'd22);
        dec_reg = 5'd22; dec_fp = 1'b1; #2;
        check_val("R2 same cycle", {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd},
                  {1'b0, 6'd22, 1'b0, 2'b00, 1'b0});
        @(posedge clk);
        m_vld[7] = 1'b1; m_word[7] = cfg_word & 16'hbfff;
        #1 cfg_we = 1'b0;
        check_val("R2 next edge", {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd},
                  {1'b1, 6'd2, 1'b1, 2'b01, 1'b0});

        // R8: outputs follow input changes without a clock edge
        @(negedge clk);
        check("R8 comb a", 5'd10, 1'b0);
        check("R8 comb b", 5'd22, 1'b1);
        check("R8 comb c", 5'd11, 1'b1);

        // R9: rewrite entry 9 with a new key, old key falls back to entry 2
        wr(4'd9, mk(0, 0, 0, 2'b10, 0, 5'd1, 5'd13));
        dec_reg = 5'd12; dec_fp = 1'b0; #1;
        check_val("R9 old key", {dec_hit, dec_phys, dec_vec, dec_ew, dec_simd},
                  {1'b1, 6'd8, 1'b0, 2'b11, 1'b1});
        check("R9 new key", 5'd13, 1'b0);

        // random mix, keys in 0..7 to force conflicts (R6, R9, R3, R4)
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 3) == 0) begin
                logic [15:0] w;
                w = 16'($urandom);
                w[4:0] = 5'($urandom % 8);
                wr(4'($urandom % 16), w);
            end else begin
                @(negedge clk);
                check("R6 random", 5'($urandom % 8), 1'($urandom % 2));
            end
        end

        // R1: reset again, everything misses
        @(negedge clk) rst_n = 1'b0;
        for (int i = 0; i < 16; i++) m_vld[i] = 0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        for (int r = 0; r < 8; r++) check("R1 rereset", 5'(r), 1'($urandom % 2));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule